// File: doc/BRIEF.md
# Branch Trace Message Encoder

This block sits next to a processor core and turns its stream of retirement and control-flow events into compact trace messages, delivered one byte at a time to a trace buffer. A small counter tracks how many instructions retired without producing a message. Each exception, direct branch or indirect branch yields a one-byte header carrying that count in its low nibble. Indirect branches then append their 32-bit target as four more bytes. When the counter runs past its 4-bit range, a fixed roll-over byte is inserted.

Entries are formed in the cycle their event arrives and placed in a short queue that accepts up to two entries per cycle. A serializer drains the queue through a valid/ready byte port. If the consumer stalls long enough for the queue to fill, entries that do not fit are discarded and a sticky flag records the loss.

Top module: `trace_msg_encoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tm_valid_o` and `ovf_o` are low.
- R2: Each cycle with `retire_i` high adds one to the word count. Every header byte carries the count in bits [3:0], and the count returns to zero after any event header is formed. A retirement in the same cycle as an event is counted before that event's header is formed.
- R3: An exception header is {1'b0, `exc_vec_hi_i`[2:0], count}, and no address bytes follow it.
- R4: A direct branch header has bits [7:4] = 4'b1000, or 4'b1100 when `ckpt_i` is high, and no address bytes follow it.
- R5: An indirect branch header has bits [7:4] = 4'b1001, or 4'b1101 when `ckpt_i` is high. It is followed by the four bytes of `target_i`, least-significant byte first, on the next four accepted transfers.
- R6: A retirement that arrives while the count is 15 produces the byte 8'hFF and leaves the count at zero.
- R7: When a roll-over and an event occur in the same cycle, 8'hFF is delivered first, followed by the event header with count zero.
- R8: A byte transfers only when `tm_valid_o` and `tm_ready_i` are both high. While valid is high and ready is low, valid stays high and `tm_data_o` holds its value. Bytes leave in the order their entries were formed.
- R9: When a cycle's entries do not all fit in the free queue slots, every entry of that cycle is discarded and `ovf_o` goes high. It stays high until reset, and the entries already queued are still delivered intact.
- R10: When several event strobes are high in one cycle, only one header is formed. Exception wins over indirect branch, and indirect branch wins over direct branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired without a message of its own |
| exc_i | input | 1 | Exception taken this cycle |
| exc_vec_hi_i | input | 3 | Exception vector bits [4:2] |
| dbr_i | input | 1 | Direct branch taken this cycle |
| ibr_i | input | 1 | Indirect branch taken this cycle |
| ckpt_i | input | 1 | Branch event is checkpointed |
| target_i | input | ADDR_W | Indirect branch target address |
| tm_valid_o | output | 1 | Output byte is valid |
| tm_data_o | output | 8 | Output trace byte |
| tm_ready_i | input | 1 | Consumer accepts the byte |
| ovf_o | output | 1 | Sticky queue-overflow flag |

## Verification
The counter-step and counter-clear properties assume that the strobes and `tm_ready_i` are known, 0 or 1, in every cycle after reset. The stimulus drives every input from time zero and changes inputs only on falling edges. The hold property places no limit on how long ready may stay low, so the bench holds it low for long stretches and also toggles it at random. Outside the overflow scenario, the bench lets the core issue events only while its own model shows enough free queue room for two entries. In the overflow scenario, it deliberately fills the queue with ready held low.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;

   localparam int HDR_W    = 8;
   localparam int CNT_W    = 4;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [HDR_W-1:0] ROLL_BYTE = 8'hFF;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_EXC  = 2'd1,
      EV_DIR  = 2'd2,
      EV_IND  = 2'd3
   } ev_kind_e;

   function automatic logic [HDR_W-1:0] make_hdr(ev_kind_e kind, logic ckpt,
                                                logic [2:0] vec, logic [CNT_W-1:0] cnt);
      logic [HDR_W-1:0] h;
      case (kind)
         EV_EXC:  h = {1'b0, vec, cnt};
         EV_DIR:  h = {1'b1, ckpt, 2'b00, cnt};
         EV_IND:  h = {1'b1, ckpt, 2'b01, cnt};
         default: h = '0;
      endcase
      return h;
   endfunction

endpackage

// File: rtl/trace_word_counter.sv
module trace_word_counter
   import trace_enc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             exc_i,
   input  logic             dbr_i,
   input  logic             ibr_i,
   input  logic             ckpt_i,
   input  logic [2:0]       vec_i,
   output logic             roll_o,
   output logic             ev_valid_o,
   output logic             ev_ind_o,
   output logic [HDR_W-1:0] ev_hdr_o,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   ev_kind_e         kind;

   always_comb begin
      if (exc_i)      kind = EV_EXC;
      else if (ibr_i) kind = EV_IND;
      else if (dbr_i) kind = EV_DIR;
      else            kind = EV_NONE;
   end

   always_comb begin
      roll_o = retire_i && (cnt_q == CNT_MAX);
      if (roll_o) base = '0;
      else        base = cnt_q + CNT_W'(retire_i);
      ev_valid_o = (kind != EV_NONE);
      ev_ind_o   = (kind == EV_IND);
      ev_hdr_o   = make_hdr(kind, ckpt_i, vec_i, base);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (ev_valid_o) cnt_q <= '0;
      else                 cnt_q <= base;
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/trace_entry_fifo.sv
module trace_entry_fifo #(
   parameter int WIDTH = 41,
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       n_push_i,
   input  logic [WIDTH-1:0] din0_i,
   input  logic [WIDTH-1:0] din1_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] head_o,
   output logic             empty_o,
   output logic             drop_o,
   output logic [CW-1:0]    occupancy_o
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             wr_ok;
   logic             do_pop;

   always_comb begin
      wr_ok   = (int'(cnt_q) + int'(n_push_i)) <= DEPTH;
      drop_o  = (n_push_i != 2'd0) && !wr_ok;
      empty_o = (cnt_q == '0);
      do_pop  = pop_i && !empty_o;
      head_o  = mem[rp_q];
   end

   always_ff @(posedge clk) begin
      if (wr_ok && n_push_i != 2'd0) mem[wp_q] <= din0_i;
      if (wr_ok && n_push_i == 2'd2) mem[wp_q + PW'(1)] <= din1_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (wr_ok) wp_q <= wp_q + PW'(n_push_i);
         if (do_pop) rp_q <= rp_q + PW'(1);
         cnt_q <= cnt_q + (wr_ok ? CW'(n_push_i) : CW'(0)) - CW'(do_pop);
      end
   end

   assign occupancy_o = cnt_q;

endmodule

// File: rtl/trace_byte_serializer.sv
module trace_byte_serializer
   import trace_enc_pkg::*;
#(
   parameter int ADDR_W = 32,
   localparam int NB = ADDR_W / 8,
   localparam int IW = $clog2(NB + 1),
   localparam int EW = 1 + HDR_W + ADDR_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EW-1:0]    head_i,
   input  logic             empty_i,
   output logic             pop_o,
   output logic             tm_valid_o,
   output logic [HDR_W-1:0] tm_data_o,
   input  logic             tm_ready_i
);

   logic [EW-1:0]     cur_q;
   logic              cur_v_q;
   logic [IW-1:0]     idx_q;
   logic [7:0]        abyte [NB];
   logic              has_addr;
   logic              last;
   logic              fire;

   for (genvar b = 0; b < NB; b++) begin : g_abyte
      assign abyte[b] = cur_q[8*b +: 8];
   end

   always_comb begin
      has_addr = cur_q[EW-1];
      last     = !has_addr || (idx_q == IW'(NB));
      fire     = cur_v_q && tm_ready_i;
      pop_o    = (!cur_v_q || (fire && last)) && !empty_i;
      tm_data_o = cur_q[ADDR_W +: HDR_W];
      for (int b = 0; b < NB; b++) begin
         if (idx_q == IW'(b + 1)) tm_data_o = abyte[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_v_q <= 1'b0;
         idx_q   <= '0;
         cur_q   <= '0;
      end else if (pop_o) begin
         cur_q   <= head_i;
         cur_v_q <= 1'b1;
         idx_q   <= '0;
      end else if (fire) begin
         if (last) cur_v_q <= 1'b0;
         else      idx_q   <= idx_q + IW'(1);
      end
   end

   assign tm_valid_o = cur_v_q;

endmodule

// File: rtl/trace_msg_encoder.sv
module trace_msg_encoder
   import trace_enc_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 32,
   localparam int EW = 1 + HDR_W + ADDR_W,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire_i,
   input  logic              exc_i,
   input  logic [2:0]        exc_vec_hi_i,
   input  logic              dbr_i,
   input  logic              ibr_i,
   input  logic              ckpt_i,
   input  logic [ADDR_W-1:0] target_i,
   output logic              tm_valid_o,
   output logic [7:0]        tm_data_o,
   input  logic              tm_ready_i,
   output logic              ovf_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 8 || (ADDR_W % 8) != 0) begin : g_bad_addr
      $error("ADDR_W must be a positive multiple of 8");
   end

   logic             roll;
   logic             ev_any;
   logic             ev_ind;
   logic [HDR_W-1:0] ev_hdr;
   logic [CNT_W-1:0] word_cnt;
   logic [EW-1:0]    ev_ent, roll_ent, din0, din1;
   logic [1:0]       n_push;
   logic [EW-1:0]    head;
   logic             empty, pop, drop;
   logic [CW-1:0]    fifo_cnt;
   logic             ovf_q;

   trace_word_counter u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .retire_i   (retire_i),
      .exc_i      (exc_i),
      .dbr_i      (dbr_i),
      .ibr_i      (ibr_i),
      .ckpt_i     (ckpt_i),
      .vec_i      (exc_vec_hi_i),
      .roll_o     (roll),
      .ev_valid_o (ev_any),
      .ev_ind_o   (ev_ind),
      .ev_hdr_o   (ev_hdr),
      .cnt_o      (word_cnt)
   );

   always_comb begin
      ev_ent   = {ev_ind, ev_hdr, ev_ind ? target_i : ADDR_W'(0)};
      roll_ent = {1'b0, ROLL_BYTE, ADDR_W'(0)};
      if (roll) begin
         din0   = roll_ent;
         din1   = ev_ent;
         n_push = ev_any ? 2'd2 : 2'd1;
      end else begin
         din0   = ev_ent;
         din1   = ev_ent;
         n_push = ev_any ? 2'd1 : 2'd0;
      end
   end

   trace_entry_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .n_push_i    (n_push),
      .din0_i      (din0),
      .din1_i      (din1),
      .pop_i       (pop),
      .head_o      (head),
      .empty_o     (empty),
      .drop_o      (drop),
      .occupancy_o (fifo_cnt)
   );

   trace_byte_serializer #(.ADDR_W(ADDR_W)) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_i     (head),
      .empty_i    (empty),
      .pop_o      (pop),
      .tm_valid_o (tm_valid_o),
      .tm_data_o  (tm_data_o),
      .tm_ready_i (tm_ready_i)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    ovf_q <= 1'b0;
      else if (drop) ovf_q <= 1'b1;
   end

   assign ovf_o = ovf_q;

endmodule

// File: rtl/trace_msg_encoder_chk.sv
module trace_msg_encoder_chk #(
   parameter int DEPTH = 8,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tm_valid_o,
   input logic [7:0]    tm_data_o,
   input logic          tm_ready_i,
   input logic          ovf_o,
   input logic          retire_i,
   input logic          ev_any,
   input logic [3:0]    word_cnt,
   input logic [CW-1:0] fifo_cnt
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!tm_valid_o && !ovf_o));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tm_valid_o && !tm_ready_i) |=> (tm_valid_o && $stable(tm_data_o)));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   assert_no_overfill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fifo_cnt) <= DEPTH);

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !ev_any && word_cnt != 4'hF) |=> (word_cnt == 4'($past(word_cnt) + 4'd1)));

   assert_count_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_any |=> (word_cnt == 4'd0));

   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && !ev_any && word_cnt == 4'hF) |=> (word_cnt == 4'd0));

endmodule

bind trace_msg_encoder trace_msg_encoder_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tm_valid_o (tm_valid_o),
   .tm_data_o  (tm_data_o),
   .tm_ready_i (tm_ready_i),
   .ovf_o      (ovf_o),
   .retire_i   (retire_i),
   .ev_any     (ev_any),
   .word_cnt   (word_cnt),
   .fifo_cnt   (fifo_cnt)
);

// File: tb/tb_trace_msg_encoder.sv
module tb_trace_msg_encoder;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        retire_i, exc_i, dbr_i, ibr_i, ckpt_i, tm_ready_i;
   logic [2:0]  exc_vec_hi_i;
   logic [31:0] target_i;
   logic        tm_valid_o, ovf_o;
   logic [7:0]  tm_data_o;

   int checks = 0;
   int failures = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         start_q[$];
   int         mcnt;
   int         pending;
   bit         exp_ovf;
   logic       prev_valid, prev_ready;
   logic [7:0] prev_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   trace_msg_encoder #(.DEPTH(DEPTH), .ADDR_W(32)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .retire_i     (retire_i),
      .exc_i        (exc_i),
      .exc_vec_hi_i (exc_vec_hi_i),
      .dbr_i        (dbr_i),
      .ibr_i        (ibr_i),
      .ckpt_i       (ckpt_i),
      .target_i     (target_i),
      .tm_valid_o   (tm_valid_o),
      .tm_data_o    (tm_data_o),
      .tm_ready_i   (tm_ready_i),
      .ovf_o        (ovf_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
      end
   endtask

   task automatic push_b(input logic [7:0] b, input string tag, input bit s);
      exp_q.push_back(b);
      tag_q.push_back(tag);
      start_q.push_back(s);
      if (s) pending++;
   endtask

   task automatic model_clear();
      exp_q.delete();
      tag_q.delete();
      start_q.delete();
      mcnt = 0;
      pending = 0;
      prev_valid = 1'b0;
      prev_ready = 1'b0;
      prev_data = '0;
   endtask

   // One cycle: check outputs at the falling edge, drive inputs, advance the model
   task automatic step(input logic r, input logic e, input logic d, input logic i,
                       input logic c, input logic [2:0] v, input logic [31:0] t,
                       input logic rdy, input string tg, input bit mdl);
      int base;
      logic [7:0] hb;
      @(negedge clk);
      chk(ovf_o == exp_ovf, "R9", "overflow flag", ovf_o, exp_ovf);
      if (prev_valid && !prev_ready) begin
         chk(tm_valid_o == 1'b1, "R8", "valid held", tm_valid_o, 1);
         chk(tm_data_o == prev_data, "R8", "data held", tm_data_o, prev_data);
      end
      if (tm_valid_o && rdy) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8", "unexpected byte", tm_data_o, 0);
         end else begin
            chk(tm_data_o == exp_q[0], tag_q[0], "byte", tm_data_o, exp_q[0]);
            if (start_q[0]) pending--;
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            void'(start_q.pop_front());
         end
      end
      prev_valid = tm_valid_o;
      prev_ready = rdy;
      prev_data  = tm_data_o;
      retire_i = r; exc_i = e; dbr_i = d; ibr_i = i; ckpt_i = c;
      exc_vec_hi_i = v; target_i = t; tm_ready_i = rdy;
      if (mdl) begin
         if (r && mcnt == 15) begin
            push_b(8'hFF, "R6", 1'b1);
            base = 0;
         end else begin
            base = mcnt + int'(r);
         end
         if (e || d || i) begin
            if (e)      hb = {1'b0, v, 4'(base)};
            else if (i) hb = {1'b1, c, 2'b01, 4'(base)};
            else        hb = {1'b1, c, 2'b00, 4'(base)};
            push_b(hb, tg, 1'b1);
            if (!e && i) begin
               for (int k = 0; k < 4; k++) push_b(t[8*k +: 8], "R5", 1'b0);
            end
            mcnt = 0;
         end else begin
            mcnt = base;
         end
      end
   endtask

   task automatic idle(input int n, input logic rdy);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 3'd0, 32'd0, rdy, "R8", 1'b1);
   endtask

   task automatic retire_n(input int n);
      for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0, 3'd0, 32'd0, 1'b1, "R2", 1'b1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      retire_i = 0; exc_i = 0; dbr_i = 0; ibr_i = 0; ckpt_i = 0;
      exc_vec_hi_i = '0; target_i = '0; tm_ready_i = 0;
      repeat (2) @(negedge clk);
      chk(tm_valid_o == 1'b0, "R1", "valid in reset", tm_valid_o, 0);
      chk(ovf_o == 1'b0, "R1", "overflow in reset", ovf_o, 0);
      rst_n = 1'b1;
      exp_ovf = 1'b0;
      model_clear();
      @(negedge clk);
      chk(tm_valid_o == 1'b0, "R1", "valid after reset", tm_valid_o, 0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      exp_ovf = 1'b0;
      model_clear();
      do_reset();

      // R2 / R4: three retirements then a plain direct branch -> 0x83
      retire_n(3);
      step(0, 0, 1, 0, 0, 3'd0, 32'd0, 1'b1, "R4", 1'b1);
      // R4: checkpointed direct branch with count 0 -> 0xC0
      step(0, 0, 1, 0, 1, 3'd0, 32'd0, 1'b1, "R4", 1'b1);
      // R3: two retirements then exception, vector[4:2]=101 -> 0x52
      retire_n(2);
      step(0, 1, 0, 0, 0, 3'b101, 32'd0, 1'b1, "R3", 1'b1);
      // R5: checkpointed indirect -> 0xD0, D4, C3, B2, A1
      step(0, 0, 0, 1, 1, 3'd0, 32'hA1B2C3D4, 1'b1, "R5", 1'b1);
      idle(8, 1'b1);
      // R6: sixteen retirements -> 0xFF, then direct branch 0x80
      retire_n(16);
      step(0, 0, 1, 0, 0, 3'd0, 32'd0, 1'b1, "R6", 1'b1);
      // R7: count at 15, retirement plus indirect in one cycle -> 0xFF, 0x90, address
      retire_n(15);
      step(1, 0, 0, 1, 0, 3'd0, 32'h0BADF00D, 1'b1, "R7", 1'b1);
      // R7: retirement with event in one cycle counts first -> 0x83
      retire_n(2);
      step(1, 0, 1, 0, 0, 3'd0, 32'd0, 1'b1, "R7", 1'b1);
      // R10: all three strobes -> exception only, 0x30
      step(0, 1, 1, 1, 1, 3'b011, 32'hFFFF_FFFF, 1'b1, "R10", 1'b1);
      // R8: stall the consumer across an indirect entry
      step(0, 0, 0, 1, 0, 3'd0, 32'h12345678, 1'b0, "R8", 1'b1);
      idle(6, 1'b0);
      idle(10, 1'b1);

      // R2 / R8: random traffic, throttled by model occupancy
      for (int n = 0; n < 3000; n++) begin
         logic r, e, d, i, c, rdy;
         int sel;
         rdy = ($urandom_range(0, 9) < 7);
         r = 0; e = 0; d = 0; i = 0;
         c = 1'($urandom);
         if (pending <= DEPTH - 3) begin
            r = ($urandom_range(0, 9) < 6);
            sel = $urandom_range(0, 19);
            e = (sel == 0);
            d = (sel == 1 || sel == 2);
            i = (sel == 3 || sel == 4);
         end
         step(r, e, d, i, c, 3'($urandom), $urandom, rdy, "R2", 1'b1);
      end
      idle(60, 1'b1);
      chk(exp_q.size() == 0, "R2", "bytes left undelivered", exp_q.size(), 0);
      chk(tm_valid_o == 1'b0, "R2", "idle after drain", tm_valid_o, 0);

      // R9: fill the queue with ready low; the tenth entry is dropped
      for (int k = 1; k <= 12; k++) begin
         exp_ovf = (k >= 11);
         step(0, 0, 1, 0, 0, 3'd0, 32'd0, 1'b0, "R9", (k <= 9));
      end
      exp_ovf = 1'b1;
      idle(3, 1'b0);
      idle(30, 1'b1);
      chk(exp_q.size() == 0, "R9", "queued entries delivered", exp_q.size(), 0);
      chk(tm_valid_o == 1'b0, "R9", "nothing beyond queued entries", tm_valid_o, 0);

      // R1: reset clears the sticky flag
      do_reset();
      idle(3, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule